// File: doc/BRIEF.md
# MDIO Management Register File with Link-Change Interrupt

This block is the management slave of a PHY. A station manager talks to it over a two-wire serial bus: a management clock (MDC, at most 2.5 MHz) and a data line that both sides can drive. Every frame carries an operation code, a 5-bit PHY address and a 5-bit register number. The block answers only when the address matches its static address pins. It holds a small set of 16-bit registers with several bit behaviours: read-write, read-only, self-clearing, latch-low, latch-high and clear-on-read counting.

The serial line is oversampled in the block's system clock domain. MDC and the data input pass through two-flop synchronisers, and all register state lives in the system clock domain. The data line is brought out as a separate input, output and output enable, so that the pad can be placed outside the block.

A link-change interrupt output tells the host that the link input has toggled. Its active level is programmable. The host acknowledges it by writing any value to a dedicated register. If further changes arrive before the acknowledge, one event is held pending. The acknowledge then releases the output for a fixed gap of about 125 ns, timed in system clocks, and the output asserts again.

Top module: `mdio_regfile_top`

## Requirements
- R1: A frame is a preamble of 32 ones, start bits 0 then 1, an opcode (10 = read, 01 = write), the PHY address MSB first, the register number MSB first, two turnaround bits and 16 data bits MSB first. The block samples the data input on rising MDC edges and changes its own output only after rising MDC edges. On a read it leaves the line undriven for the first turnaround bit, drives 0 for the second, then drives the 16 data bits, and releases the line after the last one.
- R2: Register 0 resets to 0x3000. Bits 14..7 are read-write, bits 6..0 read as 0, and `ctl_word` mirrors register 0 at all times.
- R3: A frame whose address differs from `phy_addr`, or whose opcode is 00 or 11, changes no register and never drives the data line.
- R4: Register 1 bit 6 reads 1. A frame with fewer than 32 preamble ones is ignored unless register 24 bit 5 is 1, in which case a frame may begin without any preamble.
- R5: Writing 1 to register 0 bit 15 restores register 0 to 0x3000, register 24 to 0 and register 26 to 0. Bit 15 clears itself after one clock and reads back as 0.
- R6: Register 1 bit 2 is the link bit and latches low. Once `link_up` has been low, the bit reads 0 until a read of register 1; after that read it follows `link_up` again. After reset it reads 0 until the first read.
- R7: Register 1 bit 4 is the remote-fault bit and latches high. A one-cycle pulse on `remote_fault` makes it read 1 until a read of register 1. The other bits of register 1 are fixed: bits 14..11, 6, 3 and 0 are 1 (0x7849 with link and fault clear).
- R8: Register 26 counts system-clock cycles with `rx_err` high. It saturates at 0xFFFF, clears on every read of itself, and clears when `speed_chg` is pulsed.
- R9: A change on `link_up` asserts `irq_out`. When register 24 bit 13 is 0 the output is active low (idle 1); when that bit is 1 it is active high.
- R10: A write of any value to register 21 acknowledges the interrupt. If no further change occurred since assertion, the output goes inactive. If one or more changes occurred, the output goes inactive for exactly ceil(125 ns / clock period) cycles (32 at 4 ns), then asserts again. Only one event is queued, however many changes occurred.
- R11: Registers 2 and 3 return the identifier parameters and ignore writes. Registers 21 and all unassigned numbers read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mdc | input | 1 | Management clock from the station manager |
| mdio_i | input | 1 | Management data line as seen at the pad |
| mdio_o | output | 1 | Data the block drives when enabled |
| mdio_oe | output | 1 | Output enable for the management data pad |
| phy_addr | input | 5 | Static PHY address |
| link_up | input | 1 | Current link state |
| remote_fault | input | 1 | Remote-fault indication |
| rx_err | input | 1 | Receive symbol error, counted per clock |
| speed_chg | input | 1 | Pulse on a line-speed change |
| ctl_word | output | 16 | Current value of register 0 |
| irq_out | output | 1 | Link-change interrupt, programmable level |

## Verification
On every cycle, assertions check the following:
- the turnaround bit driven at the start of a read is 0;
- the soft-reset bit never stays high for two clocks;
- the link and fault latches hold their latched value until a status read;
- the error counter does not wrap;
- a pending interrupt event only exists while the interrupt is busy;
- an acknowledge always takes the output out of its asserted state.

Only the bench's scenarios can show the rest: the exact bit position at which read data appears on the line, that frames for other addresses or with a short preamble leave the registers unchanged, the length of the deassert gap in clocks, and that several link changes collapse into one queued event.

// File: rtl/mdio_pkg.sv
// Package: shared types and register numbers for the MDIO register file.
// Assumes register numbers fit the 5-bit field of a management frame.
package mdio_pkg;

    typedef enum logic [2:0] {
        SER_IDLE,
        SER_START,
        SER_HDR,
        SER_RD_TA,
        SER_RD_DATA,
        SER_WR,
        SER_SKIP
    } ser_state_t;

    typedef enum logic [1:0] {
        IRQ_IDLE,
        IRQ_ACTIVE,
        IRQ_GAP
    } irq_state_t;

    localparam logic [4:0] RA_CTRL   = 5'd0;
    localparam logic [4:0] RA_STAT   = 5'd1;
    localparam logic [4:0] RA_IDHI   = 5'd2;
    localparam logic [4:0] RA_IDLO   = 5'd3;
    localparam logic [4:0] RA_IRQACK = 5'd21;
    localparam logic [4:0] RA_VEND   = 5'd24;
    localparam logic [4:0] RA_ERRCNT = 5'd26;

    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_WRITE = 2'b01;

    localparam int VEND_POL_BIT   = 13;
    localparam int VEND_NOPRE_BIT = 5;

endpackage

// File: rtl/mdio_serial.sv
// Module: mdio_serial
// Decodes management frames from oversampled MDC/MDIO and drives read data.
// Assumes each MDC phase lasts at least four system clocks; inputs pass
// through two-flop synchronisers. Emits one-clock read and write strobes.
module mdio_serial
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 32,
    parameter int DW      = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mdc,
    input  logic          mdio_i,
    input  logic [4:0]    phy_addr,
    input  logic          nopre_en,
    input  logic [DW-1:0] rd_data,
    output logic          mdio_o,
    output logic          mdio_oe,
    output logic [4:0]    reg_addr,
    output logic          rd_stb,
    output logic          wr_stb,
    output logic [DW-1:0] wr_data
);

    localparam int PCW = $clog2(PRE_LEN + 1);
    localparam int HW  = 12;
    localparam int CW  = $clog2(DW + 3);
    localparam logic [PCW-1:0] PRE_MAX   = PCW'(PRE_LEN);
    localparam logic [CW-1:0]  HDR_LAST  = CW'(HW - 1);
    localparam logic [CW-1:0]  DATA_LAST = CW'(DW);
    localparam logic [CW-1:0]  TAIL_LAST = CW'(DW + 1);

    logic [2:0]     mdc_sync;
    logic [1:0]     dat_sync;
    logic           mdc_rise;
    logic           bit_s;
    ser_state_t     st_q;
    logic [PCW-1:0] pre_q;
    logic [CW-1:0]  cnt_q;
    logic [HW-2:0]  hdr_q;
    logic [HW-1:0]  hdr_nxt;
    logic [DW-1:0]  shf_q;

    // Synchronise MDC and data into the system clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdc_sync <= 3'b000;
            dat_sync <= 2'b11;
        end else begin
            mdc_sync <= {mdc_sync[1:0], mdc};
            dat_sync <= {dat_sync[0], mdio_i};
        end
    end

    assign mdc_rise = mdc_sync[1] & ~mdc_sync[2];
    assign bit_s    = dat_sync[1];
    assign hdr_nxt  = {hdr_q, bit_s};

    // Frame state machine: advances by one bit on each rising MDC edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= SER_IDLE;
            pre_q    <= '0;
            cnt_q    <= '0;
            hdr_q    <= '0;
            shf_q    <= '0;
            reg_addr <= '0;
            rd_stb   <= 1'b0;
            wr_stb   <= 1'b0;
            wr_data  <= '0;
            mdio_o   <= 1'b0;
            mdio_oe  <= 1'b0;
        end else begin
            rd_stb <= 1'b0;
            wr_stb <= 1'b0;
            if (rd_stb) begin
                shf_q <= rd_data;
            end
            if (mdc_rise) begin
                case (st_q)
                    SER_IDLE: begin
                        if (bit_s) begin
                            if (pre_q != PRE_MAX) pre_q <= pre_q + 1'b1;
                        end else begin
                            if (pre_q == PRE_MAX || nopre_en) st_q <= SER_START;
                            pre_q <= '0;
                        end
                    end
                    SER_START: begin
                        st_q  <= bit_s ? SER_HDR : SER_IDLE;
                        cnt_q <= '0;
                    end
                    SER_HDR: begin
                        hdr_q <= hdr_nxt[HW-2:0];
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == HDR_LAST) begin
                            cnt_q    <= '0;
                            reg_addr <= hdr_nxt[4:0];
                            if (hdr_nxt[9:5] != phy_addr) begin
                                st_q <= SER_SKIP;
                            end else if (hdr_nxt[11:10] == OP_READ) begin
                                st_q   <= SER_RD_TA;
                                rd_stb <= 1'b1;
                            end else if (hdr_nxt[11:10] == OP_WRITE) begin
                                st_q <= SER_WR;
                            end else begin
                                st_q <= SER_SKIP;
                            end
                        end
                    end
                    SER_RD_TA: begin
                        mdio_oe <= 1'b1;
                        mdio_o  <= 1'b0;
                        cnt_q   <= '0;
                        st_q    <= SER_RD_DATA;
                    end
                    SER_RD_DATA: begin
                        if (cnt_q == DATA_LAST) begin
                            mdio_oe <= 1'b0;
                            st_q    <= SER_IDLE;
                        end else begin
                            mdio_o <= shf_q[DW-1];
                            shf_q  <= {shf_q[DW-2:0], 1'b0};
                            cnt_q  <= cnt_q + 1'b1;
                        end
                    end
                    SER_WR: begin
                        shf_q <= {shf_q[DW-2:0], bit_s};
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == TAIL_LAST) begin
                            wr_stb  <= 1'b1;
                            wr_data <= {shf_q[DW-2:0], bit_s};
                            st_q    <= SER_IDLE;
                        end
                    end
                    SER_SKIP: begin
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == TAIL_LAST) st_q <= SER_IDLE;
                    end
                    default: st_q <= SER_IDLE;
                endcase
            end
        end
    end

    AST_TA_DRIVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_o); // R1
    AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> !mdio_oe); // R3

endmodule

// File: rtl/mdio_regs.sv
// Module: mdio_regs
// Register file: control, status latches, identifiers, vendor control and
// the saturating receive-error counter. Assumes strobes last one clock and
// that reg_addr is stable while a strobe is high.
module mdio_regs
    import mdio_pkg::*;
#(
    parameter logic [15:0] ID_HI = 16'h0A5C,
    parameter logic [15:0] ID_LO = 16'h4C21
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [4:0]  reg_addr,
    input  logic        rd_stb,
    input  logic        wr_stb,
    input  logic [15:0] wr_data,
    input  logic        link_up,
    input  logic        remote_fault,
    input  logic        rx_err,
    input  logic        speed_chg,
    output logic [15:0] rd_data,
    output logic [15:0] ctl_word,
    output logic        irq_pol,
    output logic        nopre_en,
    output logic        irq_ack
);

    localparam logic [7:0]  CTL_RST  = 8'b0110_0000;
    localparam logic [15:0] STAT_FIX = 16'h7849;
    localparam logic [15:0] CNT_MAX  = 16'hFFFF;

    logic [7:0]  ctl_q;
    logic        soft_q;
    logic [15:0] vend_q;
    logic [15:0] err_q;
    logic        lat_link;
    logic        lat_rf;
    logic        soft_req;
    logic        rd_stat;
    logic        rd_err;

    assign soft_req = wr_stb && (reg_addr == RA_CTRL) && wr_data[15];
    assign rd_stat  = rd_stb && (reg_addr == RA_STAT);
    assign rd_err   = rd_stb && (reg_addr == RA_ERRCNT);

    // Writable control registers, soft reset pulse and acknowledge pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q   <= CTL_RST;
            soft_q  <= 1'b0;
            vend_q  <= '0;
            irq_ack <= 1'b0;
        end else begin
            soft_q  <= 1'b0;
            irq_ack <= 1'b0;
            if (soft_req) begin
                soft_q <= 1'b1;
                ctl_q  <= CTL_RST;
                vend_q <= '0;
            end else if (wr_stb) begin
                case (reg_addr)
                    RA_CTRL:   ctl_q   <= wr_data[14:7];
                    RA_VEND:   vend_q  <= wr_data;
                    RA_IRQACK: irq_ack <= 1'b1;
                    default:   ;
                endcase
            end
        end
    end

    // Status latches: link latches low, remote fault latches high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_link <= 1'b0;
            lat_rf   <= 1'b0;
        end else if (rd_stat) begin
            lat_link <= link_up;
            lat_rf   <= remote_fault;
        end else begin
            lat_link <= lat_link & link_up;
            lat_rf   <= lat_rf | remote_fault;
        end
    end

    // Receive-error counter: saturating, cleared on read, speed change, soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= '0;
        end else if (speed_chg || soft_req) begin
            err_q <= '0;
        end else if (rd_err) begin
            err_q <= {15'd0, rx_err};
        end else if (rx_err && err_q != CNT_MAX) begin
            err_q <= err_q + 1'b1;
        end
    end

    // Read multiplexer.
    always_comb begin
        case (reg_addr)
            RA_CTRL:   rd_data = ctl_word;
            RA_STAT:   rd_data = STAT_FIX | {11'd0, lat_rf, 1'b0, lat_link, 2'b00};
            RA_IDHI:   rd_data = ID_HI;
            RA_IDLO:   rd_data = ID_LO;
            RA_VEND:   rd_data = vend_q;
            RA_ERRCNT: rd_data = err_q;
            default:   rd_data = '0;
        endcase
    end

    assign ctl_word = {soft_q, ctl_q, 7'd0};
    assign irq_pol  = vend_q[VEND_POL_BIT];
    assign nopre_en = vend_q[VEND_NOPRE_BIT];

    AST_SOFT_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_word[15] |=> !ctl_word[15]); // R5
    AST_LINK_LATCH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_up && !rd_stat) |=> !lat_link); // R6
    AST_FAULT_LATCH_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (remote_fault && !rd_stat) |=> lat_rf); // R7
    AST_ERR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q == CNT_MAX && !rd_err && !speed_chg && !soft_req) |=> (err_q == CNT_MAX)); // R8

endmodule

// File: rtl/link_irq.sv
// Module: link_irq
// Link-change interrupt with one queued event and a timed deassert gap.
// Assumes the link input is synchronous to clk. The first cycle after reset
// only captures the link level and raises no event.
module link_irq
    import mdio_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 4000,
    parameter int GAP_NS        = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic link_up,
    input  logic ack,
    input  logic pol,
    output logic irq_out
);

    localparam int GAP_CYC = (GAP_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
    localparam int GW      = $clog2(GAP_CYC + 1);
    localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYC - 1);

    irq_state_t    st_q;
    logic          pend_q;
    logic          link_q;
    logic          prime_q;
    logic [GW-1:0] gap_q;
    logic          chg;

    assign chg = prime_q && (link_up != link_q);

    // Remember the previous link level to detect changes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_q  <= 1'b0;
            prime_q <= 1'b0;
        end else begin
            link_q  <= link_up;
            prime_q <= 1'b1;
        end
    end

    // Interrupt state: idle, asserted, or timed gap before reassertion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= IRQ_IDLE;
            pend_q <= 1'b0;
            gap_q  <= '0;
        end else begin
            case (st_q)
                IRQ_IDLE: begin
                    if (chg) st_q <= IRQ_ACTIVE;
                end
                IRQ_ACTIVE: begin
                    if (ack) begin
                        gap_q  <= '0;
                        pend_q <= 1'b0;
                        st_q   <= (pend_q || chg) ? IRQ_GAP : IRQ_IDLE;
                    end else if (chg) begin
                        pend_q <= 1'b1;
                    end
                end
                IRQ_GAP: begin
                    if (chg) pend_q <= 1'b1;
                    if (gap_q == GAP_LAST) st_q <= IRQ_ACTIVE;
                    else gap_q <= gap_q + 1'b1;
                end
                default: st_q <= IRQ_IDLE;
            endcase
        end
    end

    assign irq_out = (st_q == IRQ_ACTIVE) ? pol : ~pol;

    AST_CHANGE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (chg && st_q == IRQ_IDLE) |=> (st_q == IRQ_ACTIVE)); // R9
    AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && st_q == IRQ_ACTIVE) |=> (st_q != IRQ_ACTIVE)); // R10
    AST_PEND_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> (st_q != IRQ_IDLE)); // R10

endmodule

// File: rtl/mdio_regfile_top.sv
// Module: mdio_regfile_top
// Management slave top: serial frame engine, register file and link
// interrupt. Assumes MDC runs well below clk/8 and that the data line has
// an external pull-up at the pad.
module mdio_regfile_top
    import mdio_pkg::*;
#(
    parameter int          CLK_PERIOD_PS = 4000,
    parameter int          GAP_NS        = 125,
    parameter int          PRE_LEN       = 32,
    parameter logic [15:0] ID_HI         = 16'h0A5C,
    parameter logic [15:0] ID_LO         = 16'h4C21
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mdc,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic [4:0]  phy_addr,
    input  logic        link_up,
    input  logic        remote_fault,
    input  logic        rx_err,
    input  logic        speed_chg,
    output logic [15:0] ctl_word,
    output logic        irq_out
);

    logic [4:0]  reg_addr;
    logic        rd_stb;
    logic        wr_stb;
    logic [15:0] wr_data;
    logic [15:0] rd_data;
    logic        irq_pol;
    logic        nopre_en;
    logic        irq_ack;

    mdio_serial #(.PRE_LEN(PRE_LEN), .DW(16)) u_ser (
        .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_i(mdio_i),
        .phy_addr(phy_addr), .nopre_en(nopre_en), .rd_data(rd_data),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .reg_addr(reg_addr),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_data(wr_data)
    );

    mdio_regs #(.ID_HI(ID_HI), .ID_LO(ID_LO)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .rd_stb(rd_stb),
        .wr_stb(wr_stb), .wr_data(wr_data), .link_up(link_up),
        .remote_fault(remote_fault), .rx_err(rx_err), .speed_chg(speed_chg),
        .rd_data(rd_data), .ctl_word(ctl_word), .irq_pol(irq_pol),
        .nopre_en(nopre_en), .irq_ack(irq_ack)
    );

    link_irq #(.CLK_PERIOD_PS(CLK_PERIOD_PS), .GAP_NS(GAP_NS)) u_irq (
        .clk(clk), .rst_n(rst_n), .link_up(link_up), .ack(irq_ack),
        .pol(irq_pol), .irq_out(irq_out)
    );

endmodule

// File: tb/mdio_regfile_top_test.sv
// Bench: drives management frames bit by bit and checks ports against
// values derived from the requirements.
module mdio_regfile_top_test;

    localparam logic [4:0]  PHY     = 5'h13;
    localparam logic [15:0] IDH     = 16'h0A5C;
    localparam logic [15:0] IDL     = 16'h4C21;
    localparam int          EXP_GAP = (125 * 1000 + 4000 - 1) / 4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mdc = 1'b0;
    logic        mdio_i = 1'b1;
    logic        mdio_o;
    logic        mdio_oe;
    logic [4:0]  phy_addr = PHY;
    logic        link_up = 1'b1;
    logic        remote_fault = 1'b0;
    logic        rx_err = 1'b0;
    logic        speed_chg = 1'b0;
    logic [15:0] ctl_word;
    logic        irq_out;

    int   n_tests = 0;
    int   n_fail = 0;
    logic done = 1'b0;
    logic oe_seen = 1'b0;
    logic act_lvl = 1'b0;
    int   inact_run = 0;
    int   last_gap = 0;
    logic last_ok;

    always #2 clk = ~clk;

    mdio_regfile_top uut (
        .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_i(mdio_i),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .phy_addr(phy_addr),
        .link_up(link_up), .remote_fault(remote_fault), .rx_err(rx_err),
        .speed_chg(speed_chg), .ctl_word(ctl_word), .irq_out(irq_out)
    );

    // Monitor: output-enable activity and length of inactive interrupt runs.
    always @(negedge clk) begin
        if (mdio_oe) oe_seen = 1'b1;
        if (irq_out != act_lvl) inact_run = inact_run + 1;
        else begin
            if (inact_run > 0) last_gap = inact_run;
            inact_run = 0;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bit_cycle(input logic b, output logic soe, output logic so);
        @(negedge clk);
        mdc = 1'b0;
        mdio_i = b;
        repeat (4) @(negedge clk);
        soe = mdio_oe;
        so = mdio_o;
        repeat (4) @(negedge clk);
        mdc = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic frame(input logic [1:0] op, input logic [4:0] pa, input logic [4:0] ra,
                         input logic [15:0] wd, input int pre, output logic [15:0] rd);
        logic [31:0] body;
        logic soe, so;
        last_ok = 1'b1;
        rd = '0;
        body = {2'b01, op, pa, ra, (op == 2'b01) ? {2'b10, wd} : 18'h3FFFF};
        for (int i = 0; i < pre; i++) bit_cycle(1'b1, soe, so);
        for (int j = 0; j < 32; j++) begin
            bit_cycle(body[31-j], soe, so);
            if (j == 14 && soe) last_ok = 1'b0;
            if (j == 15 && !(soe && !so)) last_ok = 1'b0;
            if (j >= 16) begin
                if (!soe) last_ok = 1'b0;
                rd[31-j] = so;
            end
        end
        bit_cycle(1'b1, soe, so);
        if (soe) last_ok = 1'b0;
    endtask

    task automatic wr(input logic [4:0] ra, input logic [15:0] wd);
        logic [15:0] d;
        frame(2'b01, PHY, ra, wd, 32, d);
    endtask

    task automatic rd(input logic [4:0] ra, output logic [15:0] d);
        frame(2'b10, PHY, ra, 16'h0, 32, d);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [15:0] d;
        logic [15:0] exp;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // Reset state: R2 control mirror and R9 idle interrupt level.
        check("R2 ctl_word after reset", ctl_word, 16'h3000);
        check("R9 irq idle high after reset", irq_out, 1'b1);
        check("R1 line released after reset", mdio_oe, 1'b0);

        // Sweep of every register number after reset: R11, R2, R7, R6, R8.
        for (int r = 0; r < 32; r++) begin
            rd(5'(r), d);
            case (r)
                0: exp = 16'h3000;
                1: exp = 16'h7849;
                2: exp = IDH;
                3: exp = IDL;
                default: exp = 16'h0000;
            endcase
            check($sformatf("R11 reset read reg %0d", r), d, exp);
            if (r == 0) check("R1 turnaround and data framing", last_ok, 1'b1);
        end

        // R2: control write, low bits ignored, mirror output.
        wr(5'd0, 16'h217F);
        rd(5'd0, d);
        check("R2 reg0 write readback", d, 16'h2100);
        check("R2 ctl_word mirror", ctl_word, 16'h2100);

        // R11: identifier registers ignore writes.
        wr(5'd2, 16'hFFFF);
        rd(5'd2, d);
        check("R11 id register read-only", d, IDH);

        // R3: address mismatch on each address bit, and bad opcodes.
        for (int b = 0; b < 5; b++) begin
            oe_seen = 1'b0;
            frame(2'b01, PHY ^ (5'd1 << b), 5'd24, 16'hFFFF, 32, d);
            frame(2'b10, PHY ^ (5'd1 << b), 5'd0, 16'h0, 32, d);
            check($sformatf("R3 no drive for foreign address bit %0d", b), oe_seen, 1'b0);
        end
        oe_seen = 1'b0;
        frame(2'b11, PHY, 5'd0, 16'h0, 32, d);
        frame(2'b00, PHY, 5'd24, 16'hFFFF, 32, d);
        check("R3 no drive for bad opcode", oe_seen, 1'b0);
        rd(5'd24, d);
        check("R3 reg24 unchanged by ignored frames", d, 16'h0000);

        // R4: short preamble ignored unless suppression enabled.
        frame(2'b01, PHY, 5'd0, 16'h2180, 0, d);
        rd(5'd0, d);
        check("R4 frame without preamble ignored", d, 16'h2100);
        wr(5'd24, 16'h0020);
        frame(2'b01, PHY, 5'd0, 16'h0180, 0, d);
        rd(5'd0, d);
        check("R4 frame without preamble accepted", d, 16'h0180);

        // R8: counting, clear on read, speed change, saturation.
        for (int i = 0; i < 5; i++) begin
            @(negedge clk) rx_err = 1'b1;
            @(negedge clk) rx_err = 1'b0;
        end
        rd(5'd26, d);
        check("R8 error count", d, 16'd5);
        rd(5'd26, d);
        check("R8 clear on read", d, 16'd0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk) rx_err = 1'b1;
            @(negedge clk) rx_err = 1'b0;
        end
        @(negedge clk) speed_chg = 1'b1;
        @(negedge clk) speed_chg = 1'b0;
        rd(5'd26, d);
        check("R8 clear on speed change", d, 16'd0);
        @(negedge clk) rx_err = 1'b1;
        repeat (65540) @(negedge clk);
        rx_err = 1'b0;
        rd(5'd26, d);
        check("R8 saturation", d, 16'hFFFF);

        // R5: soft reset restores defaults and clears itself.
        wr(5'd0, 16'h8000);
        rd(5'd0, d);
        check("R5 reg0 back to default", d, 16'h3000);
        check("R5 ctl_word bit15 cleared", ctl_word, 16'h3000);
        rd(5'd24, d);
        check("R5 reg24 back to default", d, 16'h0000);
        rd(5'd26, d);
        check("R5 error counter cleared", d, 16'h0000);

        // R6 and R7: latch behaviour of the status bits.
        rd(5'd1, d);
        check("R6 link up reads 1", d, 16'h784D);
        @(negedge clk) link_up = 1'b0;
        repeat (3) @(negedge clk);
        link_up = 1'b1;
        rd(5'd1, d);
        check("R6 link latched low", d, 16'h7849);
        rd(5'd1, d);
        check("R6 link follows after read", d, 16'h784D);
        @(negedge clk) remote_fault = 1'b1;
        @(negedge clk) remote_fault = 1'b0;
        rd(5'd1, d);
        check("R7 fault latched high", d, 16'h785D);
        rd(5'd1, d);
        check("R7 fault clears after read", d, 16'h784D);

        // R9/R10: two link changes above left one event asserted, one pending.
        check("R9 irq asserted active low", irq_out, 1'b0);
        last_gap = 0;
        wr(5'd21, 16'h1234);
        repeat (100) @(negedge clk);
        check("R10 deassert gap length", last_gap, EXP_GAP);
        check("R10 gap within 100..150 ns", (last_gap * 4 >= 100 && last_gap * 4 <= 150), 1'b1);
        check("R10 reasserted after gap", irq_out, 1'b0);
        wr(5'd21, 16'h0000);
        repeat (200) @(negedge clk);
        check("R10 single queued event", irq_out, 1'b1);

        @(negedge clk) link_up = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 single change asserts", irq_out, 1'b0);
        wr(5'd21, 16'hFFFF);
        repeat (100) @(negedge clk);
        check("R10 ack without pending releases", irq_out, 1'b1);
        @(negedge clk) link_up = 1'b1;
        repeat (3) @(negedge clk);
        wr(5'd21, 16'h0001);

        // R9: active-high polarity.
        act_lvl = 1'b1;
        wr(5'd24, 16'h2000);
        repeat (4) @(negedge clk);
        check("R9 idle level with high polarity", irq_out, 1'b0);
        @(negedge clk) link_up = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 asserted high", irq_out, 1'b1);
        wr(5'd21, 16'h5555);
        repeat (4) @(negedge clk);
        check("R10 ack with high polarity", irq_out, 1'b0);

        done = 1'b1;
        finish_run();
    end

endmodule